// File: doc/BRIEF.md
# FPGA Volatile Configuration Loader

This block configures an FPGA straight into its volatile configuration memory over a serial link. On a start pulse it pulls the target's active-low reset and chip-select low together, holds them, releases reset while chip select stays low, and waits for the target to wake. It then accepts image bytes on a ready/valid stream and shifts each byte out most significant bit first. After the stream ends it issues a fixed run of dummy clocks, raises both control lines, and reports the level of the target's configuration-done input.

A second mode lets an outside agent reach the configuration flash that sits on the same wires. While this mode is held, target reset stays low and chip select follows a select input. When the mode is dropped, both lines go high. After a boot delay the done level is reported.

All delays and the serial clock half period are counted in system clocks. They are derived from a clock-frequency parameter and from a duration parameter for each delay.

Top module: `cfg_loader`

## Requirements
- R1: After reset, tgt_cs_n and tgt_rst_n are 1, sclk, mosi, img_ready, busy and result_valid are 0.
- R2: A start_load pulse while idle drives tgt_cs_n and tgt_rst_n low together for exactly RST_CYC = CLK_HZ*RST_US/1e6 cycles (minimum 1).
- R3: After that hold, tgt_rst_n goes high while tgt_cs_n stays low. At least WAKE_CYC = CLK_HZ*WAKE_US/1e6 cycles pass before the first rising sclk edge.
- R4: Each image byte is sent most significant bit first. sclk idles low, mosi is sampled by the target on the rising sclk edge, and mosi changes only when sclk falls, never while sclk is high.
- R5: After the beat marked img_last, exactly DUMMY_CLKS (default 49) extra sclk pulses are sent with mosi low. A load of N bytes therefore gives 8*N+DUMMY_CLKS rising edges.
- R6: A beat accepted with img_keep=0 sends no bits. A stream made only of one such beat with img_last=1 still yields the dummy clocks and a report.
- R7: After the dummy clocks, tgt_cs_n and tgt_rst_n return high. result_valid then pulses for one cycle, with result_pass equal to tgt_done at that moment.
- R8: The sclk high and low phases each last max(1, CLK_HZ/(2*FAST_HZ)) cycles. If slow_sclk was 1 at start, they last max(1, CLK_HZ/(2*SLOW_HZ)) cycles instead.
- R9: While flash_mode is held, tgt_rst_n stays low, and tgt_cs_n equals !flash_sel. Deselecting (flash_sel=0) keeps tgt_rst_n low.
- R10: When flash_mode drops, tgt_rst_n and tgt_cs_n both go high. result_valid pulses BOOT_CYC+1 cycles after the drop, carrying tgt_done.
- R11: start_load is ignored while busy. A pulse during a load starts no second reset sequence and no second report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_load | input | 1 | Pulse to begin a volatile load |
| slow_sclk | input | 1 | Selects the slow serial clock, sampled at start |
| flash_mode | input | 1 | Level: hold the target in reset for flash access |
| flash_sel | input | 1 | Flash select request while flash_mode is held |
| img_data | input | 8 | Image byte |
| img_valid | input | 1 | Image beat valid |
| img_last | input | 1 | Final beat of the image |
| img_keep | input | 1 | Beat carries a byte (0: beat is dropped) |
| img_ready | output | 1 | Loader accepts a beat |
| tgt_done | input | 1 | Configuration-done level from the target |
| sclk | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| tgt_cs_n | output | 1 | Active-low chip select to the target |
| tgt_rst_n | output | 1 | Active-low reset to the target |
| busy | output | 1 | Sequence in progress |
| result_valid | output | 1 | One-cycle report strobe |
| result_pass | output | 1 | Done level captured at the report |

## Verification
The bench sweeps image lengths of zero to three bytes, at both clock speeds, with the done input high and low. Each byte value comes from an arithmetic formula, so a bit-order or shift-count error shows as a byte mismatch and not as a timing shift. Some loads mix in dropped beats. The empty load separates "no bytes" from "no dummy clocks", and one load receives a stray start pulse mid-stream. The flash mode is run with the select toggled in both directions and the boot delay counted exactly. This separates hold-in-reset behaviour from the release timing.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST,
        ST_WAKE,
        ST_FETCH,
        ST_SHIFT,
        ST_DUMMY,
        ST_DWAIT,
        ST_FINISH,
        ST_FLASH,
        ST_BOOT
    } ld_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic [3:0] nbits;
    } shift_req_t;

    // cycles of clk_hz that fit in a duration given in microseconds, at least 1
    function automatic int unsigned us_to_cycles(longint unsigned clk_hz, longint unsigned us);
        longint unsigned c;
        c = (clk_hz * us) / 64'd1_000_000;
        if (c == 0) c = 1;
        return c[31:0];
    endfunction

    // clk cycles per half period of a serial clock, at least 1
    function automatic int unsigned half_cycles(longint unsigned clk_hz, longint unsigned sclk_hz);
        longint unsigned c;
        c = clk_hz / (2 * sclk_hz);
        if (c == 0) c = 1;
        return c[31:0];
    endfunction

endpackage

// File: rtl/cl_delay.sv
module cl_delay #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] value,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= value;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R2
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);

endmodule

// File: rtl/cl_bit_shifter.sv
module cl_bit_shifter
    import cfg_loader_pkg::*;
#(
    parameter int unsigned HW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  shift_req_t    req,
    input  logic [HW-1:0] half,
    output logic          sclk,
    output logic          mosi,
    output logic          busy,
    output logic          done
);
    logic [7:0]    sh;
    logic [3:0]    left;
    logic [HW-1:0] hcnt;
    logic          ph;
    logic          act;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            left   <= '0;
            hcnt   <= '0;
            ph     <= 1'b0;
            act    <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !act) begin
                sh   <= req.data;
                left <= req.nbits;
                hcnt <= '0;
                ph   <= 1'b0;
                act  <= 1'b1;
            end else if (act) begin
                if (hcnt == half - 1'b1) begin
                    hcnt <= '0;
                    if (!ph) begin
                        ph <= 1'b1;
                    end else begin
                        ph   <= 1'b0;
                        sh   <= {sh[6:0], 1'b0};
                        left <= left - 4'd1;
                        if (left == 4'd1) begin
                            act    <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end

    assign sclk = act & ph;
    assign mosi = act & sh[7];
    assign busy = act;
    assign done = done_q;

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R4
    shift_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/cl_load_seq.sv
module cl_load_seq
    import cfg_loader_pkg::*;
#(
    parameter int unsigned RST_CYC    = 10,
    parameter int unsigned WAKE_CYC   = 10,
    parameter int unsigned BOOT_CYC   = 10,
    parameter int unsigned FAST_HALF  = 1,
    parameter int unsigned SLOW_HALF  = 4,
    parameter int unsigned DUMMY_CLKS = 49,
    parameter int unsigned TW         = 8,
    parameter int unsigned HW         = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_load,
    input  logic          slow_sclk,
    input  logic          flash_mode,
    input  logic          flash_sel,
    input  logic          tgt_done,
    input  logic [7:0]    img_data,
    input  logic          img_valid,
    input  logic          img_last,
    input  logic          img_keep,
    output logic          img_ready,
    output logic          tgt_cs_n,
    output logic          tgt_rst_n,
    output logic          busy,
    output logic          result_valid,
    output logic          result_pass,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_value,
    input  logic          tmr_zero,
    output logic          sh_start,
    output shift_req_t    sh_req,
    output logic [HW-1:0] sh_half,
    input  logic          sh_done,
    input  logic          sh_sclk
);
    localparam int unsigned FULL = DUMMY_CLKS / 8;
    localparam int unsigned REM  = DUMMY_CLKS % 8;
    localparam int unsigned NCH  = FULL + ((REM != 0) ? 1 : 0);
    localparam int unsigned CW   = $clog2(NCH + 1);
    localparam int unsigned DRW  = $clog2(DUMMY_CLKS + 1);

    ld_state_e    st, nxt;
    logic         last_q;
    logic         slow_q;
    logic [CW-1:0] chunk;
    logic         final_chunk;

    assign final_chunk = (chunk == CW'(NCH - 1));

    always_comb begin
        nxt       = st;
        tmr_load  = 1'b0;
        tmr_value = '0;
        sh_start  = 1'b0;
        sh_req    = '{data: img_data, nbits: 4'd8};
        case (st)
            ST_IDLE: begin
                if (flash_mode) begin
                    nxt = ST_FLASH;
                end else if (start_load) begin
                    nxt       = ST_RST;
                    tmr_load  = 1'b1;
                    tmr_value = TW'(RST_CYC - 1);
                end
            end
            ST_RST: begin
                if (tmr_zero) begin
                    nxt       = ST_WAKE;
                    tmr_load  = 1'b1;
                    tmr_value = TW'(WAKE_CYC - 1);
                end
            end
            ST_WAKE:  if (tmr_zero) nxt = ST_FETCH;
            ST_FETCH: begin
                if (img_valid) begin
                    if (img_keep) begin
                        sh_start = 1'b1;
                        nxt      = ST_SHIFT;
                    end else if (img_last) begin
                        nxt = ST_DUMMY;
                    end
                end
            end
            ST_SHIFT: if (sh_done) nxt = last_q ? ST_DUMMY : ST_FETCH;
            ST_DUMMY: begin
                sh_start     = 1'b1;
                sh_req.data  = 8'h00;
                sh_req.nbits = (final_chunk && REM != 0) ? 4'(REM) : 4'd8;
                nxt          = ST_DWAIT;
            end
            ST_DWAIT: if (sh_done) nxt = final_chunk ? ST_FINISH : ST_DUMMY;
            ST_FINISH: nxt = ST_IDLE;
            ST_FLASH: begin
                if (!flash_mode) begin
                    nxt       = ST_BOOT;
                    tmr_load  = 1'b1;
                    tmr_value = TW'(BOOT_CYC - 1);
                end
            end
            ST_BOOT: if (tmr_zero) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            last_q       <= 1'b0;
            slow_q       <= 1'b0;
            chunk        <= '0;
            result_valid <= 1'b0;
            result_pass  <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && start_load && !flash_mode)
                slow_q <= slow_sclk;
            if (st == ST_FETCH && img_valid && img_keep)
                last_q <= img_last;
            if (st == ST_FETCH)
                chunk <= '0;
            else if (st == ST_DWAIT && sh_done)
                chunk <= chunk + 1'b1;
            result_valid <= (st == ST_FINISH) || (st == ST_BOOT && tmr_zero);
            if ((st == ST_FINISH) || (st == ST_BOOT && tmr_zero))
                result_pass <= tgt_done;
        end
    end

    assign sh_half   = slow_q ? HW'(SLOW_HALF) : HW'(FAST_HALF);
    assign img_ready = (st == ST_FETCH);
    assign busy      = (st != ST_IDLE);
    assign tgt_rst_n = !(st == ST_RST || st == ST_FLASH);
    assign tgt_cs_n  = !((st == ST_RST) || (st == ST_WAKE) || (st == ST_FETCH) ||
                         (st == ST_SHIFT) || (st == ST_DUMMY) || (st == ST_DWAIT) ||
                         (st == ST_FLASH && flash_sel));

    // checker state: rising serial clock edges seen during the dummy run
    logic           sclk_q;
    logic [DRW-1:0] drise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            drise  <= '0;
        end else begin
            sclk_q <= sh_sclk;
            if (st == ST_IDLE || st == ST_FETCH)
                drise <= '0;
            else if ((st == ST_DUMMY || st == ST_DWAIT) && sh_sclk && !sclk_q)
                drise <= drise + 1'b1;
        end
    end

    // R5
    dummy_count_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FINISH) |-> (drise == DRW'(DUMMY_CLKS)));

    // R7
    report_pins_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> ($past(tgt_cs_n) && $past(tgt_rst_n) && !$past(sh_sclk)));

    // R9
    flash_rst_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FLASH) |-> !sh_sclk);

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 100_000_000,
    parameter longint unsigned FAST_HZ    = 6_000_000,
    parameter longint unsigned SLOW_HZ    = 50_000,
    parameter longint unsigned RST_US     = 100,
    parameter longint unsigned WAKE_US    = 2_000,
    parameter longint unsigned BOOT_US    = 250_000,
    parameter int unsigned     DUMMY_CLKS = 49
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_load,
    input  logic       slow_sclk,
    input  logic       flash_mode,
    input  logic       flash_sel,
    input  logic [7:0] img_data,
    input  logic       img_valid,
    input  logic       img_last,
    input  logic       img_keep,
    output logic       img_ready,
    input  logic       tgt_done,
    output logic       sclk,
    output logic       mosi,
    output logic       tgt_cs_n,
    output logic       tgt_rst_n,
    output logic       busy,
    output logic       result_valid,
    output logic       result_pass
);
    localparam int unsigned RST_CYC   = us_to_cycles(CLK_HZ, RST_US);
    localparam int unsigned WAKE_CYC  = us_to_cycles(CLK_HZ, WAKE_US);
    localparam int unsigned BOOT_CYC  = us_to_cycles(CLK_HZ, BOOT_US);
    localparam int unsigned FAST_HALF = half_cycles(CLK_HZ, FAST_HZ);
    localparam int unsigned SLOW_HALF = half_cycles(CLK_HZ, SLOW_HZ);
    localparam int unsigned MAX_A     = (RST_CYC > WAKE_CYC) ? RST_CYC : WAKE_CYC;
    localparam int unsigned MAX_CYC   = (MAX_A > BOOT_CYC) ? MAX_A : BOOT_CYC;
    localparam int unsigned TW        = $clog2(MAX_CYC + 1);
    localparam int unsigned MAX_HALF  = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int unsigned HW        = $clog2(MAX_HALF + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_value;
    logic          tmr_zero;
    logic          sh_start;
    shift_req_t    sh_req;
    logic [HW-1:0] sh_half;
    logic          sh_done;
    logic          sh_busy;

    cl_delay #(.TW(TW)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .load  (tmr_load),
        .value (tmr_value),
        .zero  (tmr_zero)
    );

    cl_bit_shifter #(.HW(HW)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .req   (sh_req),
        .half  (sh_half),
        .sclk  (sclk),
        .mosi  (mosi),
        .busy  (sh_busy),
        .done  (sh_done)
    );

    cl_load_seq #(
        .RST_CYC    (RST_CYC),
        .WAKE_CYC   (WAKE_CYC),
        .BOOT_CYC   (BOOT_CYC),
        .FAST_HALF  (FAST_HALF),
        .SLOW_HALF  (SLOW_HALF),
        .DUMMY_CLKS (DUMMY_CLKS),
        .TW         (TW),
        .HW         (HW)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_load   (start_load),
        .slow_sclk    (slow_sclk),
        .flash_mode   (flash_mode),
        .flash_sel    (flash_sel),
        .tgt_done     (tgt_done),
        .img_data     (img_data),
        .img_valid    (img_valid),
        .img_last     (img_last),
        .img_keep     (img_keep),
        .img_ready    (img_ready),
        .tgt_cs_n     (tgt_cs_n),
        .tgt_rst_n    (tgt_rst_n),
        .busy         (busy),
        .result_valid (result_valid),
        .result_pass  (result_pass),
        .tmr_load     (tmr_load),
        .tmr_value    (tmr_value),
        .tmr_zero     (tmr_zero),
        .sh_start     (sh_start),
        .sh_req       (sh_req),
        .sh_half      (sh_half),
        .sh_done      (sh_done),
        .sh_sclk      (sclk)
    );

    // R3
    wake_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (sh_busy && !flash_mode) |-> (tgt_rst_n && !tgt_cs_n));

endmodule

// File: tb/cfg_loader_test.sv
`timescale 1ns/1ps
module cfg_loader_test;
    localparam longint unsigned CLK_HZ  = 1_200_000;
    localparam longint unsigned BOOT_US = 5_000;
    localparam int RST_CYC   = 120;   // 1.2 MHz * 100 us
    localparam int WAKE_CYC  = 2400;  // 1.2 MHz * 2 ms
    localparam int BOOT_CYC  = 6000;  // 1.2 MHz * 5 ms
    localparam int FAST_HALF = 1;     // 1.2M/12M rounds to 0, floor 1
    localparam int SLOW_HALF = 12;    // 1.2M/100k
    localparam int DUMMY     = 49;

    logic clk = 0, rst = 1;
    logic start_load = 0, slow_sclk = 0, flash_mode = 0, flash_sel = 0;
    logic [7:0] img_data = 0;
    logic img_valid = 0, img_last = 0, img_keep = 0, tgt_done = 0;
    logic img_ready, sclk, mosi, tgt_cs_n, tgt_rst_n, busy, result_valid, result_pass;

    cfg_loader #(.CLK_HZ(CLK_HZ), .BOOT_US(BOOT_US)) uut (
        .clk(clk), .rst(rst), .start_load(start_load), .slow_sclk(slow_sclk),
        .flash_mode(flash_mode), .flash_sel(flash_sel), .img_data(img_data),
        .img_valid(img_valid), .img_last(img_last), .img_keep(img_keep),
        .img_ready(img_ready), .tgt_done(tgt_done), .sclk(sclk), .mosi(mosi),
        .tgt_cs_n(tgt_cs_n), .tgt_rst_n(tgt_rst_n), .busy(busy),
        .result_valid(result_valid), .result_pass(result_pass));

    always #5 clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, 190000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // monitor, sampled at the falling system clock edge
    bit mon_en = 0;
    int rstlow, wakecnt, rises, holdviol, hrun, hmin, hmax, nres;
    bit psclk, pmosi, lastpass;
    bit bits [0:1023];

    task automatic mon_clear();
        rstlow = 0; wakecnt = 0; rises = 0; holdviol = 0; hrun = 0;
        hmin = 1 << 20; hmax = 0; nres = 0; psclk = 0; pmosi = 0;
    endtask

    always @(negedge clk) if (mon_en) begin
        if (!tgt_cs_n && !tgt_rst_n) rstlow++;
        if (tgt_rst_n && !tgt_cs_n && rises == 0) wakecnt++;
        if (sclk && !psclk) begin bits[rises] = mosi; rises++; end
        if (sclk && psclk && mosi != pmosi) holdviol++;
        if (sclk) hrun++;
        else begin
            if (psclk) begin
                if (hrun > hmax) hmax = hrun;
                if (hrun < hmin) hmin = hrun;
            end
            hrun = 0;
        end
        if (result_valid) begin nres++; lastpass = result_pass; end
        psclk = sclk; pmosi = mosi;
    end

    function automatic logic [7:0] pat(input int k, input int i);
        return 8'((k * 37 + i * 91 + 90) & 255);
    endfunction

    task automatic send_beat(input logic [7:0] d, input bit keep, input bit last);
        int g;
        @(negedge clk);
        img_data = d; img_keep = keep; img_last = last; img_valid = 1;
        g = 0;
        while (!img_ready && g < 20000) begin @(negedge clk); g++; end
        @(posedge clk);
    endtask

    task automatic do_load(input bit slow, input int n, input int k, input bit lvl,
                           input bit skip, input bit poke);
        int t, bad, dz, half;
        mon_clear();
        tgt_done = lvl; slow_sclk = slow;
        @(negedge clk); start_load = 1; mon_en = 1;
        @(negedge clk); start_load = 0;
        for (int i = 0; i < n; i++) begin
            if (skip) send_beat(8'hFF, 0, 0);
            send_beat(pat(k, i), 1, i == n - 1);
        end
        if (n == 0) send_beat(8'hA5, 0, 1);
        @(negedge clk); img_valid = 0;
        if (poke) begin
            start_load = 1; @(negedge clk); start_load = 0;
        end
        t = 0;
        while (nres == 0 && t < 20000) begin @(posedge clk); t++; end
        repeat (6) @(posedge clk);
        mon_en = 0;
        half = slow ? SLOW_HALF : FAST_HALF;
        // R2
        chk(rstlow == RST_CYC, "R2 reset hold", rstlow, RST_CYC);
        // R3
        chk(wakecnt >= WAKE_CYC && wakecnt <= WAKE_CYC + 2 * half + 6, "R3 wake", wakecnt, WAKE_CYC);
        // R5 / R6
        chk(rises == 8 * n + DUMMY, "R5 R6 clock count", rises, 8 * n + DUMMY);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            for (int j = 0; j < 8; j++) b[7 - j] = bits[i * 8 + j];
            if (b != pat(k, i)) bad++;
        end
        // R4
        chk(bad == 0, "R4 msb-first bytes", bad, 0);
        chk(holdviol == 0, "R4 mosi steady while high", holdviol, 0);
        dz = 0;
        for (int j = 8 * n; j < rises; j++) if (bits[j]) dz++;
        // R5
        chk(dz == 0, "R5 dummy bits low", dz, 0);
        // R8
        chk(hmin == half && hmax == half, "R8 half period", hmax, half);
        // R7 / R11
        chk(nres == 1, "R7 R11 one report", nres, 1);
        chk(lastpass == lvl, "R7 done level", lastpass, lvl);
        chk(tgt_cs_n && tgt_rst_n && !busy, "R7 R11 pins high idle", {tgt_cs_n, tgt_rst_n, busy}, 3'b110);
    endtask

    task automatic do_flash(input bit lvl);
        int t;
        tgt_done = lvl;
        @(negedge clk); flash_mode = 1;
        repeat (3) @(negedge clk);
        // R9
        chk(!tgt_rst_n && tgt_cs_n, "R9 held, deselected", {tgt_rst_n, tgt_cs_n}, 2'b01);
        mon_clear(); mon_en = 1;
        start_load = 1; @(negedge clk); start_load = 0;
        flash_sel = 1; @(negedge clk);
        chk(!tgt_rst_n && !tgt_cs_n, "R9 selected", {tgt_rst_n, tgt_cs_n}, 2'b00);
        flash_sel = 0; @(negedge clk);
        chk(!tgt_rst_n && tgt_cs_n, "R9 deselect keeps reset", {tgt_rst_n, tgt_cs_n}, 2'b01);
        repeat (4) @(negedge clk);
        mon_en = 0;
        // R11
        chk(rises == 0 && nres == 0, "R11 start ignored in flash", rises + nres, 0);
        flash_mode = 0;
        t = 0;
        @(negedge clk); t++;
        chk(tgt_rst_n && tgt_cs_n, "R10 both released", {tgt_rst_n, tgt_cs_n}, 2'b11);
        while (!result_valid && t < 20000) begin @(negedge clk); t++; end
        // R10
        chk(t == BOOT_CYC + 1, "R10 boot delay", t, BOOT_CYC + 1);
        chk(result_pass == lvl, "R10 done level", result_pass, lvl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(tgt_cs_n && tgt_rst_n && !sclk && !mosi && !img_ready && !busy && !result_valid,
            "R1 reset state", {tgt_cs_n, tgt_rst_n, sclk, mosi, img_ready, busy, result_valid}, 7'b1100000);
        rst = 0;
        repeat (2) @(negedge clk);
        chk(tgt_cs_n && tgt_rst_n && !busy, "R1 idle after reset", {tgt_cs_n, tgt_rst_n, busy}, 3'b110);
        for (int s = 0; s < 2; s++)
            for (int n = 0; n < 4; n++)
                do_load(s[0], n, s * 4 + n, ((s + n) % 2) == 0, (n % 2) == 1, n == 2);
        do_flash(1);
        do_flash(0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule